// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block turns one block-transfer request into a stream of per-word transfer slots. A request carries a base address, a 16-bit mask with one bit per register, an addressing mode and a writeback flag. The block then issues one slot per accepted cycle. Each slot names the register to move and the byte address of its 32-bit word. Registers go out in ascending index order at ascending addresses, four bytes apart. Data movement, the memory port and the register file belong to the surrounding logic, which consumes the slots.

The four modes encode direction and timing: increment-after, increment-before, decrement-after and decrement-before. Together they cover every stack style, whether full or empty, ascending or descending. A full-descending push uses decrement-before, and its pop uses increment-after. A full-ascending push uses increment-before, and its pop uses decrement-after. An empty-descending push uses decrement-after, and its pop uses increment-before. An empty-ascending push uses increment-after, and its pop uses decrement-before.

The slot output is a valid/ready stream. A slot is consumed on a cycle where `xfer_valid` and `xfer_ready` are both high. While `xfer_ready` is low, the current slot stays presented unchanged, so a low ready acts as the stall input. `xfer_valid` never drops until its slot is consumed. At the end, `done` pulses, and `wb_valid` pulses with it if writeback was requested. When `wb_valid` is high, `wb_base` holds the final base address.

Top module: `mreg_xfer_seq`

## Requirements
- R1: After reset, `xfer_valid`, `done` and `wb_valid` are low.
- R2: With mode 2'b00 (increment-after), the first slot address equals the base.
- R3: With mode 2'b01 (increment-before), the first slot address equals base + 4.
- R4: With mode 2'b10 (decrement-after), the first slot address equals base - 4*N + 4, where N is the number of set mask bits.
- R5: With mode 2'b11 (decrement-before), the first slot address equals base - 4*N.
- R6: Slots carry the set mask bits in ascending register index order, and each slot address is 4 more than the previous one. The lowest register therefore sits at the lowest address in every mode.
- R7: When writeback is requested, `wb_valid` pulses together with `done`, and `wb_base` equals base + 4*N for increment modes or base - 4*N for decrement modes. Without writeback, `wb_valid` stays low. All address arithmetic wraps modulo 2^32.
- R8: An empty mask produces no slot. `done` pulses in the first cycle after the start cycle, and `wb_base` then equals the base.
- R9: While `xfer_valid` is high and `xfer_ready` is low, the slot stays valid with its address and register index unchanged.
- R10: `done` pulses for exactly one cycle, the cycle after the last slot is consumed. `xfer_valid` is low while `done` is high.
- R11: A `start` pulse that arrives while a sequence is in progress is ignored. The running sequence continues with its original base and mask, and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse, accepted only when idle |
| base_in | input | 32 | Base address of the request |
| mask_in | input | 16 | Register mask; bit i selects register i |
| mode_in | input | 2 | 00 inc-after, 01 inc-before, 10 dec-after, 11 dec-before |
| wb_in | input | 1 | Request final-base writeback |
| xfer_valid | output | 1 | Slot stream valid |
| xfer_ready | input | 1 | Slot stream ready; low stalls the sequence |
| xfer_addr | output | 32 | Byte address of the current word |
| xfer_reg | output | 4 | Register index of the current word |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Final base is valid (writeback requested) |
| wb_base | output | 32 | Final base address |

## Verification
The bench checks the start offset of all four modes against a model built from the requirements. A design that mixes up the before and after variants would show up as a sequence shifted by one word. A full 16-register decrement case and two base values near the address boundary expose any mistake in the span arithmetic or its wraparound. Irregular stall patterns catch a design that advances, or changes its address, while ready is low. An empty mask with writeback must finish at once with the base unchanged. A start pulse sent during a burst must neither restart the burst nor queue a second one.

// File: rtl/mreg_xfer_pkg.sv
package mreg_xfer_pkg;
  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'b00,
    AM_INC_BEFORE = 2'b01,
    AM_DEC_AFTER  = 2'b10,
    AM_DEC_BEFORE = 2'b11
  } addr_mode_e;

  function automatic logic mode_is_dec(addr_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_before(addr_mode_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/mreg_popcnt.sv
module mreg_popcnt #(
  parameter int NBITS = 16,
  localparam int CW = $clog2(NBITS + 1)
) (
  input  logic [NBITS-1:0] bits,
  output logic [CW-1:0]    count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NBITS; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/mreg_low_pick.sv
module mreg_low_pick #(
  parameter int NBITS = 16,
  localparam int IW = $clog2(NBITS)
) (
  input  logic [NBITS-1:0] bits,
  output logic [IW-1:0]    idx
);
  // Scan downward so the lowest set bit is the last one assigned.
  always_comb begin
    idx = '0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mreg_addr_plan.sv
module mreg_addr_plan
  import mreg_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  addr_mode_e        mode,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] low_addr,
  output logic [ADDR_W-1:0] end_base
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span;

  always_comb begin
    span = ADDR_W'(count) * STEP;
    unique case (mode)
      AM_INC_AFTER:  low_addr = base;
      AM_INC_BEFORE: low_addr = base + STEP;
      AM_DEC_AFTER:  low_addr = base - span + STEP;
      default:       low_addr = base - span;
    endcase
    end_base = mode_is_dec(mode) ? (base - span) : (base + span);
  end
endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq
  import mreg_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [NREG-1:0]   mask_in,
  input  logic [1:0]        mode_in,
  input  logic              wb_in,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [IDX_W-1:0]  xfer_reg,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_base
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic              busy_q;
  logic [NREG-1:0]   rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] end_q;
  logic              wb_q;
  logic              done_q;
  logic              wbv_q;

  logic [CNT_W-1:0]  req_cnt;
  logic [ADDR_W-1:0] req_low;
  logic [ADDR_W-1:0] req_end;
  logic [NREG-1:0]   rem_next;
  logic              take;
  logic              accept;

  mreg_popcnt #(.NBITS(NREG)) u_cnt (
    .bits  (mask_in),
    .count (req_cnt)
  );

  mreg_addr_plan #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_plan (
    .base     (base_in),
    .mode     (addr_mode_e'(mode_in)),
    .count    (req_cnt),
    .low_addr (req_low),
    .end_base (req_end)
  );

  mreg_low_pick #(.NBITS(NREG)) u_pick (
    .bits (rem_q),
    .idx  (xfer_reg)
  );

  assign accept   = start && !busy_q;
  assign take     = busy_q && xfer_ready;
  assign rem_next = rem_q & (rem_q - NREG'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      end_q  <= '0;
      wb_q   <= 1'b0;
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      if (accept) begin
        rem_q  <= mask_in;
        addr_q <= req_low;
        end_q  <= req_end;
        wb_q   <= wb_in;
        if (mask_in == '0) begin
          done_q <= 1'b1;
          wbv_q  <= wb_in;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (take) begin
        rem_q  <= rem_next;
        addr_q <= addr_q + STEP;
        if (rem_next == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          wbv_q  <= wb_q;
        end
      end
    end
  end

  assign xfer_valid = busy_q;
  assign xfer_addr  = addr_q;
  assign done       = done_q;
  assign wb_valid   = wbv_q;
  assign wb_base    = end_q;
endmodule

// File: rtl/mreg_xfer_chk.sv
module mreg_xfer_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [IDX_W-1:0]  xfer_reg,
  input logic              done,
  input logic              wb_valid
);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_reg));

  p_step_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready |=> !xfer_valid ||
      ((xfer_addr == $past(xfer_addr) + ADDR_W'(4)) && (xfer_reg > $past(xfer_reg))));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_valid);

  p_wb_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);
endmodule

bind mreg_xfer_seq mreg_xfer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_addr  (xfer_addr),
  .xfer_reg   (xfer_reg),
  .done       (done),
  .wb_valid   (wb_valid)
);

// File: tb/tb_mreg_xfer_seq.sv
module tb_mreg_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_in = '0;
  logic [15:0] mask_in = '0;
  logic [1:0]  mode_in = '0;
  logic        wb_in = 1'b0;
  logic        xfer_ready = 1'b1;
  logic        xfer_valid;
  logic [31:0] xfer_addr;
  logic [3:0]  xfer_reg;
  logic        done;
  logic        wb_valid;
  logic [31:0] wb_base;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mreg_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in),
    .mask_in(mask_in), .mode_in(mode_in), .wb_in(wb_in),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_reg(xfer_reg), .done(done), .wb_valid(wb_valid), .wb_base(wb_base)
  );

  // {base[31:0], mask[15:0], mode[1:0], wb, stall}
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {32'h0000_1000, 16'h00F0, 2'b00, 1'b1, 1'b0},
    {32'h0000_2000, 16'h8001, 2'b01, 1'b1, 1'b1},
    {32'h0000_3000, 16'h0505, 2'b10, 1'b1, 1'b0},
    {32'h0000_4000, 16'hFFFF, 2'b11, 1'b1, 1'b1},
    {32'h0000_5000, 16'h0001, 2'b11, 1'b0, 1'b0},
    {32'h0000_0004, 16'h0003, 2'b11, 1'b1, 1'b0},
    {32'h0000_6000, 16'h4000, 2'b10, 1'b1, 1'b1},
    {32'hFFFF_FFF0, 16'h0F00, 2'b00, 1'b1, 1'b0}
  };

  function automatic int pop16(logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [31:0] exp_low(logic [31:0] b, logic [15:0] m, logic [1:0] md);
    logic [31:0] span = 32'(pop16(m)) * 32'd4;
    case (md)
      2'b00:   return b;
      2'b01:   return b + 32'd4;
      2'b10:   return b - span + 32'd4;
      default: return b - span;
    endcase
  endfunction

  function automatic logic [31:0] exp_end(logic [31:0] b, logic [15:0] m, logic [1:0] md);
    logic [31:0] span = 32'(pop16(m)) * 32'd4;
    return md[1] ? b - span : b + span;
  endfunction

  function automatic int nth_bit(logic [15:0] m, int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(logic [31:0] b, logic [15:0] m, logic [1:0] md,
                         bit wb, bit stall, bit poke, string req);
    int n = pop16(m);
    int k = 0;
    int cyc = 0;
    bit ok = 1'b1;
    logic [31:0] bad_act = '0;
    logic [31:0] bad_exp = '0;
    logic [31:0] low = exp_low(b, m, md);
    @(negedge clk);
    base_in = b; mask_in = m; mode_in = md; wb_in = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < n && cyc < 400) begin
      logic [31:0] ea = low + 32'(4 * k);
      logic [3:0]  er = 4'(nth_bit(m, k));
      bit rdy = stall ? ((cyc % 3) != 1) : 1'b1;
      if (!xfer_valid || xfer_addr !== ea || xfer_reg !== er) begin
        if (ok) begin bad_act = xfer_addr; bad_exp = ea; end
        ok = 1'b0;
      end
      xfer_ready = rdy;
      if (poke && cyc == 1) begin
        start = 1'b1; base_in = b + 32'h100; mask_in = 16'h0001;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (rdy) k++;
      cyc++;
    end
    start = 1'b0;
    xfer_ready = 1'b1;
    // R6 and R9 are covered by the per-slot comparison under stall
    check(ok, {req, "/R6/R9 slot sequence"}, bad_act, bad_exp);
    check(done === 1'b1 && xfer_valid === 1'b0, "R10 done after last slot",
          {30'd0, done, xfer_valid}, 32'd2);
    check(wb_valid === wb && (!wb || wb_base === exp_end(b, m, md)), "R7 writeback",
          wb_base, exp_end(b, m, md));
    @(negedge clk);
    check(done === 1'b0 && xfer_valid === 1'b0, poke ? "R11 no second run" : "R10 single pulse",
          {30'd0, done, xfer_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(xfer_valid === 1'b0 && done === 1'b0 && wb_valid === 1'b0, "R1 reset outputs",
          {29'd0, xfer_valid, done, wb_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(xfer_valid === 1'b0 && done === 1'b0, "R1 idle after reset",
          {30'd0, xfer_valid, done}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [51:0] e = VEC[v];
      string req;
      case (e[3:2])
        2'b00:   req = "R2";
        2'b01:   req = "R3";
        2'b10:   req = "R4";
        default: req = "R5";
      endcase
      run_vec(e[51:20], e[19:4], e[3:2], e[1], e[0], 1'b0, req);
    end

    // R11: start during a burst is ignored
    run_vec(32'h0000_7000, 16'h0F0F, 2'b01, 1'b1, 1'b0, 1'b1, "R11");

    // R8: empty mask finishes at once, base unchanged
    @(negedge clk);
    base_in = 32'h0000_8000; mask_in = 16'h0000; mode_in = 2'b11; wb_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1 && xfer_valid === 1'b0 && wb_valid === 1'b1, "R8 empty done",
          {29'd0, done, xfer_valid, wb_valid}, 32'd5);
    check(wb_base === 32'h0000_8000, "R8 empty base", wb_base, 32'h0000_8000);
    @(negedge clk);
    check(done === 1'b0 && xfer_valid === 1'b0, "R8 no transfer",
          {30'd0, done, xfer_valid}, 32'd0);

    // R7: no writeback requested keeps wb_valid low
    run_vec(32'h0000_9000, 16'h0006, 2'b00, 1'b0, 1'b1, 1'b0, "R2");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule